// File: doc/BRIEF.md
# Iterative Left Shifter with Exact Signed Overflow

This block shifts a two's-complement operand left by a requested number of places. It moves one bit per clock, so each step doubles the value. A request is accepted when `start` is high while the block is idle. The operand and the count are captured on that clock edge. The block then walks the shift one step per cycle and finishes with a single-cycle `done` pulse. The sign bit is shifted like any other bit.

Two signed-overflow indications come back with the result:

- **Exact overflow** (`ovf_exact`) is built up over every step. It reports an overflow even when the value wraps and returns to its starting sign.
- **Sign-change flag** (`ovf_sign`) is the cheap check: starting sign XOR final sign. Software or a test harness can compare the two.

The block also returns the last bit that left the word (`carry`).

The input side follows a ready/valid model in which `start` is the valid strobe and `!busy` is the ready.

- A strobe is taken only on an edge where `busy` is low.
- A strobe seen while `busy` is high is dropped, not queued.
- The output side has no back-pressure. `done` is a one-cycle valid strobe.
- `result`, `carry`, `ovf_exact` and `ovf_sign` then hold their values until the next request is accepted.

Top module: `iter_shl`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `result`, `carry`, `ovf_exact` and `ovf_sign` are all 0.
- R2: The edge that accepts a request makes `busy` 1. With n = min(`count`, W), the edge n+1 clocks later drops `busy` and raises `done` for exactly one cycle.
- R3: When `done` is high, `result` equals the captured operand shifted left by n places and truncated to W bits.
- R4: When `done` is high, `carry` is bit W-n of the captured operand for n of 1 or more, and 0 for n = 0.
- R5: When `done` is high, `ovf_exact` is 1 exactly when some bit shifted out differs from `result[W-1]`.
- R6: An overflow partway through the shift is reported by `ovf_exact` even if the final sign equals the starting sign (operand 0x5000 shifted by 2 gives result 0x4000, `ovf_exact` = 1, `ovf_sign` = 0).
- R7: `ovf_sign` equals the captured operand's bit W-1 XOR `result[W-1]`. When it is 1, `ovf_exact` is also 1.
- R8: A count of zero gives `done` two edges after the accepting edge's input cycle (one busy cycle). In that case `result` equals the operand and `carry`, `ovf_exact` and `ovf_sign` are 0.
- R9: A count above W is treated as W. `result` becomes 0, `ovf_exact` is 1 exactly when the operand was non-zero, and `carry` is operand bit 0.
- R10: A `start` while `busy` is high is ignored: the running shift's result is unchanged and no extra `done` follows.
- R11: While `busy` is low, `result` and the flag outputs do not change, whatever `operand` and `count` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| operand | input | W | Two's-complement value to shift |
| count | input | CNT_W | Requested shift distance, clamped to W |
| busy | output | 1 | Shift in progress; inverse of input ready |
| done | output | 1 | One-cycle strobe: outputs valid |
| result | output | W | Shifted value |
| carry | output | 1 | Last bit shifted out |
| ovf_exact | output | 1 | Overflow over all steps |
| ovf_sign | output | 1 | Starting sign XOR final sign |

## Verification
With n = min(`count`, W), an input cycle whose `start` is accepted shows `busy` at the next edge, and `done` with valid outputs n+1 edges after that. A zero count therefore gives `done` two edges after the request. The bench keeps a behavioural model that is advanced on the same rising edge from the bench-driven inputs. It compares `busy` and `done` on every falling edge. It compares `result` and the flags on every falling edge where the model is idle, which covers the `done` cycle and the hold period after it. Directed cases for wrap-back overflow, zero count, clamping and dropped strobes are also checked by hand-worked values at the `done` cycle.

// File: rtl/ishl_pkg.sv
package ishl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } ishl_seq_e;
endpackage

// File: rtl/ishl_seq.sv
module ishl_seq
  import ishl_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic             step
);
  localparam int RW      = $clog2(W + 1);
  localparam int MAX_CNT = (1 << CNT_W) - 1;

  ishl_seq_e       state_q;
  logic [RW-1:0]   rem_q;
  logic [RW-1:0]   steps;
  logic            done_q;

  // Clamp the request to W steps only when the count field can exceed W.
  generate
    if (MAX_CNT > W) begin : g_clamp
      always_comb begin
        if (int'(count) > W) steps = RW'(W);
        else                 steps = RW'(count);
      end
    end else begin : g_direct
      always_comb steps = RW'(count);
    end
  endgenerate

  assign busy = (state_q == SEQ_RUN);
  assign done = done_q;
  assign load = start && (state_q == SEQ_IDLE);
  assign step = (state_q == SEQ_RUN) && (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            rem_q   <= steps;
          end
        end
        SEQ_RUN: begin
          if (rem_q == '0) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ishl_datapath.sv
module ishl_datapath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] operand,
  output logic [W-1:0] value,
  output logic         last_out,
  output logic         any_one,
  output logic         any_zero,
  output logic         first_sign
);
  logic [W-1:0] value_q;
  logic         last_q;
  logic         one_q;
  logic         zero_q;
  logic         sign_q;
  logic         msb;

  assign msb = value_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      last_q  <= 1'b0;
      one_q   <= 1'b0;
      zero_q  <= 1'b0;
      sign_q  <= 1'b0;
    end else if (load) begin
      value_q <= operand;
      sign_q  <= operand[W-1];
      last_q  <= 1'b0;
      one_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else if (step) begin
      value_q <= {value_q[W-2:0], 1'b0};
      last_q  <= msb;
      one_q   <= one_q | msb;
      zero_q  <= zero_q | ~msb;
    end
  end

  assign value      = value_q;
  assign last_out   = last_q;
  assign any_one    = one_q;
  assign any_zero   = zero_q;
  assign first_sign = sign_q;
endmodule

// File: rtl/ishl_flags.sv
module ishl_flags (
  input  logic top_bit,
  input  logic any_one,
  input  logic any_zero,
  input  logic first_sign,
  output logic ovf_exact,
  output logic ovf_sign
);
  // A shifted-out bit differs from the final top bit when the opposite value was seen.
  always_comb begin
    ovf_exact = top_bit ? any_zero : any_one;
    ovf_sign  = first_sign ^ top_bit;
  end
endmodule

// File: rtl/iter_shl.sv
module iter_shl #(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     operand,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result,
  output logic             carry,
  output logic             ovf_exact,
  output logic             ovf_sign
);
  logic load;
  logic step;
  logic any_one;
  logic any_zero;
  logic first_sign;

  ishl_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .count (count),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .step  (step)
  );

  ishl_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .operand    (operand),
    .value      (result),
    .last_out   (carry),
    .any_one    (any_one),
    .any_zero   (any_zero),
    .first_sign (first_sign)
  );

  ishl_flags u_flags (
    .top_bit    (result[W-1]),
    .any_one    (any_one),
    .any_zero   (any_zero),
    .first_sign (first_sign),
    .ovf_exact  (ovf_exact),
    .ovf_sign   (ovf_sign)
  );
endmodule

// File: rtl/ishl_chk.sv
module ishl_chk #(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [W-1:0]     operand,
  input logic [CNT_W-1:0] count,
  input logic             busy,
  input logic             done,
  input logic [W-1:0]     result,
  input logic             carry,
  input logic             ovf_exact,
  input logic             ovf_sign
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == '0) |=> busy ##1
      (done && result == $past(operand, 2) && !carry && !ovf_exact && !ovf_sign));

  // R7
  sign_implies_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf_sign) |-> ovf_exact);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($stable(result) && $stable(carry) && $stable(ovf_exact) && $stable(ovf_sign)));
endmodule

bind iter_shl ishl_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .operand   (operand),
  .count     (count),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .carry     (carry),
  .ovf_exact (ovf_exact),
  .ovf_sign  (ovf_sign)
);

// File: tb/tb_iter_shl.sv
`timescale 1ns/1ps
module tb_iter_shl;
  localparam int W     = 16;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [W-1:0]     operand = '0;
  logic [CNT_W-1:0] count = '0;
  logic             busy, done, carry, ovf_exact, ovf_sign;
  logic [W-1:0]     result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  iter_shl #(.W(W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .count(count),
    .busy(busy), .done(done), .result(result), .carry(carry),
    .ovf_exact(ovf_exact), .ovf_sign(ovf_sign)
  );

  // Behavioural reference: timing by countdown, values computed directly at acceptance.
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0;
  logic [W-1:0] m_res = '0;
  bit          m_carry = 0, m_exact = 0, m_sign = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
      m_res = '0; m_carry = 0; m_exact = 0; m_sign = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
        else m_left = m_left - 1;
      end else if (start) begin
        int n;
        logic [W-1:0] v;
        bit outs[$];
        n = (int'(count) > W) ? W : int'(count);
        v = operand;
        outs.delete();
        for (int i = 0; i < n; i++) begin
          outs.push_back(v[W-1]);
          v = v << 1;
        end
        m_res   = v;
        m_carry = (n == 0) ? 1'b0 : outs[n-1];
        m_exact = 0;
        foreach (outs[k]) if (outs[k] != v[W-1]) m_exact = 1;
        m_sign  = operand[W-1] ^ v[W-1];
        m_busy  = 1;
        m_left  = n;
      end
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "busy", busy, m_busy);
      check("R2", "done", done, m_done);
      if (!m_busy) begin
        check("R3", "result", result, m_res);
        check("R4", "carry", carry, m_carry);
        check("R5", "ovf_exact", ovf_exact, m_exact);
        check("R7", "ovf_sign", ovf_sign, m_sign);
      end
    end
  end

  task automatic issue(input logic [W-1:0] op, input int cnt);
    @(negedge clk);
    start = 1'b1; operand = op; count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic expect_out(input string tag, input logic [W-1:0] r, input bit c,
                            input bit ex, input bit sg);
    check(tag, "done", done, 1);
    check(tag, "result", result, r);
    check(tag, "carry", carry, c);
    check(tag, "ovf_exact", ovf_exact, ex);
    check(tag, "ovf_sign", ovf_sign, sg);
  endtask

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "result", result, 0);
    check("R1", "flags", {carry, ovf_exact, ovf_sign}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4: plain shift, 0x0123 << 4
    issue(16'h0123, 4); wait_done();
    expect_out("R3", 16'h1230, 1'b0, 1'b0, 1'b0);

    // R5: single step into sign bit, 0x5000 << 1 = 0xA000
    issue(16'h5000, 1); wait_done();
    expect_out("R5", 16'hA000, 1'b0, 1'b1, 1'b1);

    // R6: wrap back to starting sign
    issue(16'h5000, 2); wait_done();
    expect_out("R6", 16'h4000, 1'b1, 1'b1, 1'b0);

    // R5: negative value staying negative, 0xF000 << 3 = 0x8000
    issue(16'hF000, 3); wait_done();
    expect_out("R5", 16'h8000, 1'b1, 1'b0, 1'b0);

    // R8: zero count, done after one busy cycle
    @(negedge clk);
    start = 1'b1; operand = 16'hA5A5; count = '0;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy", busy, 1);
    @(negedge clk);
    expect_out("R8", 16'hA5A5, 1'b0, 1'b0, 1'b0);

    // R9: clamped counts
    issue(16'h0001, 40); wait_done();
    expect_out("R9", 16'h0000, 1'b1, 1'b1, 1'b0);
    issue(16'h0000, 63); wait_done();
    expect_out("R9", 16'h0000, 1'b0, 1'b0, 1'b0);
    issue(16'h8000, 17); wait_done();
    expect_out("R9", 16'h0000, 1'b0, 1'b1, 1'b1);

    // R10: strobe during a run is dropped
    issue(16'h0001, 3);
    start = 1'b1; operand = 16'hFFFF; count = CNT_W'(1);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    expect_out("R10", 16'h0008, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10", "no extra done", done, 0);
    repeat (3) @(negedge clk);
    check("R10", "idle", busy, 0);

    // R11: idle inputs wiggle, outputs hold
    for (int i = 0; i < 6; i++) begin
      operand = W'(16'h1111 * i); count = CNT_W'(i);
      @(negedge clk);
      check("R11", "result held", result, 16'h0008);
    end

    // Sweep of mixed operands and counts, checked by the reference model
    seed = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      issue(seed[15:0], int'(seed[21:16]));
      wait_done();
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule